// File: doc/BRIEF.md
# Reconfigurable SIMD Integer and Mantissa Multiplier

This block is a purely combinational integer multiplier built around a single partial-product array. That array can be set up in three ways. The first is one full-width 64x64 multiply. The second is two independent 32x32 multiplies on the two halves of the operands. The third is an exact multiply of two 53-bit unsigned double-precision significands. A single signedness input selects two's-complement or unsigned interpretation for the full-width and split modes.

Sign handling happens before the array. Each row of partial products is built from a multiplicand that is already sign-extended to the width of its own result lane. The row driven by the multiplier's sign bit is negated within that lane. In split mode, rows belonging to one lane are zero in the other lane's bit range, and the carry into the upper result half is cut. The array output therefore needs no correction stage.

The block has no handshake and no state. The product settles in the same cycle as the operands and mode inputs, so a surrounding pipeline registers both sides as it requires.

Top module: `simd_int_mul`

## Requirements
- R1: With `mode_sel` = 2'b00 and `is_signed` = 0, `product` equals the unsigned 128-bit product of `op_a` and `op_b`.
- R2: With `mode_sel` = 2'b00 and `is_signed` = 1, `product` equals the 128-bit two's-complement product of `op_a` and `op_b`.
- R3: With `mode_sel` = 2'b01, `product[63:0]` is the 64-bit product of `op_a[31:0]` and `op_b[31:0]`, and `product[127:64]` is the 64-bit product of `op_a[63:32]` and `op_b[63:32]`. Both lanes are unsigned when `is_signed` = 0.
- R4: With `mode_sel` = 2'b01, neither lane's result depends on the other lane's operand bits. A lane whose operands are unchanged keeps its result whatever the other lane holds, including a lane whose operand is zero.
- R5: With `mode_sel` = 2'b01 and `is_signed` = 1, each lane is the 64-bit two's-complement product of its signed 32-bit halves.
- R6: With `mode_sel` = 2'b10, bits [63:53] of both operands have no effect, and the value is the unsigned product of `op_a[52:0]` and `op_b[52:0]`.
- R7: With `mode_sel` = 2'b10, the 106-bit product sits in `product[105:0]` and `product[127:106]` is zero, whatever the value of `is_signed`.
- R8: With `mode_sel` = 2'b11 (reserved), `product` is all zero.
- R9: The block holds no state. `product` follows a change on any input within the same clock period, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 64 | Multiplicand (halves are lane operands in split mode) |
| op_b | input | 64 | Multiplier (halves are lane operands in split mode) |
| mode_sel | input | 2 | 00 full width, 01 two 32-bit lanes, 10 53-bit significand, 11 reserved |
| is_signed | input | 1 | 1 selects two's-complement operands in modes 00 and 01 |
| product | output | 128 | Full product, two 64-bit lane products, or right-aligned 106-bit significand product |

## Verification
The bench builds the block with its default parameters: a 64-bit operand width, which gives 32-bit lanes, and a 53-bit significand. These values bring the exact sign corners within reach: the most negative value times itself and times minus one, both at full width and in each lane. They also cover lane-boundary carry cases, where all-ones halves would spill into the neighbour without the carry cut, and the largest 53-bit significand squared, which fills all 106 result bits. Directed corners are mixed with pseudo-random operands and compared against a behavioural multiply that is sign-extended independently in the bench.

// File: rtl/smul_pkg.sv
package smul_pkg;
  // Operating mode codes of the multiplier (mode_sel encoding).
  typedef enum logic [1:0] {
    SM_FULL = 2'b00,
    SM_SIMD = 2'b01,
    SM_MANT = 2'b10,
    SM_RSVD = 2'b11
  } smul_mode_e;
endpackage

// File: rtl/smul_prep.sv
// Operand conditioning: significand masking and per-lane sign extension,
// so that the array needs no sign correction afterwards.
module smul_prep
  import smul_pkg::*;
#(
  parameter int W  = 64,
  parameter int MW = 53
) (
  input  logic [W-1:0]          a_in,
  input  logic [W-1:0]          b_in,
  input  smul_mode_e            mode,
  input  logic                  sgn,
  output logic [2*W-1:0]        full_mcand,
  output logic [1:0][W-1:0]     lane_mcand,
  output logic [W-1:0]          mplier,
  output logic                  full_neg,
  output logic                  lane_neg,
  output logic                  split
);
  localparam int LANE = W / 2;
  localparam logic [W-1:0] MANT_MASK = {{(W-MW){1'b0}}, {MW{1'b1}}};

  logic [W-1:0] a_eff;
  logic         full_ext;

  always_comb begin
    a_eff  = (mode == SM_MANT) ? (a_in & MANT_MASK) : a_in;
    mplier = (mode == SM_MANT) ? (b_in & MANT_MASK) : b_in;
  end

  assign full_ext   = sgn && (mode == SM_FULL) && a_eff[W-1];
  assign full_mcand = {{W{full_ext}}, a_eff};
  assign full_neg   = sgn && (mode == SM_FULL);
  assign lane_neg   = sgn && (mode == SM_SIMD);
  assign split      = (mode == SM_SIMD);

  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic [LANE-1:0] seg;
    logic            ext;
    assign seg = a_in[l*LANE +: LANE];
    assign ext = sgn && seg[LANE-1];
    assign lane_mcand[l] = {{LANE{ext}}, seg};
  end

  // R6: significand mode must never hand a high multiplier bit to the array
  always_comb begin
    if (mode == SM_MANT) begin
      p_mant_mplier_clear_r6: assert (mplier[W-1:MW] == '0)
        else $error("prep: high multiplier bit leaked in significand mode");
    end
  end
endmodule

// File: rtl/smul_pp_array.sv
// Partial-product rows. Each row is generated for the active mode; in split
// mode a row lives entirely inside its own lane.
module smul_pp_array
  import smul_pkg::*;
#(
  parameter int W  = 64,
  parameter int MW = 53
) (
  input  smul_mode_e        mode,
  input  logic [2*W-1:0]    full_mcand,
  input  logic [1:0][W-1:0] lane_mcand,
  input  logic [W-1:0]      mplier,
  input  logic              full_neg,
  input  logic              lane_neg,
  output logic [2*W-1:0]    rows [W]
);
  localparam int LANE = W / 2;

  for (genvar j = 0; j < W; j++) begin : g_row
    localparam int LN = j / LANE;
    localparam int JJ = j % LANE;
    logic [2*W-1:0] fr;
    logic [W-1:0]   lr;
    logic [2*W-1:0] rv;

    always_comb begin
      fr = mplier[j] ? (full_mcand << j) : '0;
      if (full_neg && (j == W - 1)) fr = -fr;
      lr = mplier[j] ? (lane_mcand[LN] << JJ) : '0;
      if (lane_neg && (JJ == LANE - 1)) lr = -lr;
      unique case (mode)
        SM_FULL, SM_MANT: rv = fr;
        SM_SIMD:          rv = (LN == 0) ? {{W{1'b0}}, lr} : {lr, {W{1'b0}}};
        default:          rv = '0;
      endcase
    end
    assign rows[j] = rv;

    // R4: a split-mode row must stay inside its own lane
    always_comb begin
      if (mode == SM_SIMD) begin
        if (LN == 0) begin
          p_row_in_lane0_r4: assert (rv[2*W-1:W] == '0)
            else $error("array: lane0 row %0d crosses into lane1", j);
        end else begin
          p_row_in_lane1_r4: assert (rv[W-1:0] == '0)
            else $error("array: lane1 row %0d crosses into lane0", j);
        end
      end
    end

    // R6: rows above the significand width stay idle in significand mode
    if (j >= MW) begin : g_mant_idle
      always_comb begin
        if (mode == SM_MANT) begin
          p_mant_rows_idle_r6: assert (rv == '0)
            else $error("array: row %0d active in significand mode", j);
        end
      end
    end
  end
endmodule

// File: rtl/smul_seg_reduce.sv
// Row summation with a breakable carry at the lane boundary.
module smul_seg_reduce #(
  parameter int W = 64
) (
  input  logic [2*W-1:0] rows [W],
  input  logic           split,
  output logic [2*W-1:0] sum
);
  function automatic logic [2*W-1:0] seg_add(input logic [2*W-1:0] x,
                                              input logic [2*W-1:0] y,
                                              input logic           cut);
    logic [W:0]   lo;
    logic [W-1:0] hi;
    lo = {1'b0, x[W-1:0]} + {1'b0, y[W-1:0]};
    hi = x[2*W-1:W] + y[2*W-1:W] + {{(W-1){1'b0}}, (lo[W] & ~cut)};
    return {hi, lo[W-1:0]};
  endfunction

  always_comb begin
    sum = '0;
    for (int j = 0; j < W; j++) begin
      sum = seg_add(sum, rows[j], split);
    end
  end
endmodule

// File: rtl/simd_int_mul.sv
// Top: one array for full-width, dual-lane and significand multiplies.
module simd_int_mul
  import smul_pkg::*;
#(
  parameter int W  = 64,
  parameter int MW = 53
) (
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  input  logic [1:0]     mode_sel,
  input  logic           is_signed,
  output logic [2*W-1:0] product
);
  localparam int LANE = W / 2;

  smul_mode_e        mode;
  logic [2*W-1:0]    full_mcand;
  logic [1:0][W-1:0] lane_mcand;
  logic [W-1:0]      mplier;
  logic              full_neg;
  logic              lane_neg;
  logic              split;
  logic [2*W-1:0]    rows [W];

  assign mode = smul_mode_e'(mode_sel);

  smul_prep #(.W(W), .MW(MW)) u_prep (
    .a_in       (op_a),
    .b_in       (op_b),
    .mode       (mode),
    .sgn        (is_signed),
    .full_mcand (full_mcand),
    .lane_mcand (lane_mcand),
    .mplier     (mplier),
    .full_neg   (full_neg),
    .lane_neg   (lane_neg),
    .split      (split)
  );

  smul_pp_array #(.W(W), .MW(MW)) u_array (
    .mode       (mode),
    .full_mcand (full_mcand),
    .lane_mcand (lane_mcand),
    .mplier     (mplier),
    .full_neg   (full_neg),
    .lane_neg   (lane_neg),
    .rows       (rows)
  );

  smul_seg_reduce #(.W(W)) u_reduce (
    .rows  (rows),
    .split (split),
    .sum   (product)
  );

  always_comb begin
    // R7: significand product is right-aligned with a clear top
    if (mode_sel == 2'b10) begin
      p_mant_top_zero_r7: assert (product[2*W-1:2*MW] == '0)
        else $error("top: significand product has high bits set");
    end
    // R8: reserved code yields zero
    if (mode_sel == 2'b11) begin
      p_rsvd_zero_r8: assert (product == '0)
        else $error("top: reserved mode produced a value");
    end
    // R1: unsigned full-width multiply by one returns the multiplicand
    if (mode_sel == 2'b00 && !is_signed && op_b == {{(W-1){1'b0}}, 1'b1}) begin
      p_unit_identity_r1: assert (product == {{W{1'b0}}, op_a})
        else $error("top: multiply by one mismatch");
    end
    // R4: a zero lane0 operand gives a zero lane0 result regardless of lane1
    if (mode_sel == 2'b01 && op_a[LANE-1:0] == '0) begin
      p_lane0_zero_r4: assert (product[W-1:0] == '0)
        else $error("top: lane1 disturbed lane0");
    end
  end
endmodule

// File: tb/sim_simd_int_mul.sv
module sim_simd_int_mul;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [63:0]  op_a = '0;
  logic [63:0]  op_b = '0;
  logic [1:0]   mode_sel = 2'b00;
  logic         is_signed = 1'b0;
  logic [127:0] product;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  simd_int_mul u0 (
    .op_a(op_a), .op_b(op_b), .mode_sel(mode_sel),
    .is_signed(is_signed), .product(product)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [127:0] ref_full(logic [63:0] a, logic [63:0] b, logic s);
    logic [127:0] xa, xb;
    xa = s ? {{64{a[63]}}, a} : {64'b0, a};
    xb = s ? {{64{b[63]}}, b} : {64'b0, b};
    return xa * xb;
  endfunction

  function automatic logic [63:0] ref_lane(logic [31:0] a, logic [31:0] b, logic s);
    logic [63:0] xa, xb;
    xa = s ? {{32{a[31]}}, a} : {32'b0, a};
    xb = s ? {{32{b[31]}}, b} : {32'b0, b};
    return xa * xb;
  endfunction

  function automatic logic [127:0] ref_mant(logic [63:0] a, logic [63:0] b);
    logic [127:0] xa, xb;
    xa = {75'b0, a[52:0]};
    xb = {75'b0, b[52:0]};
    return xa * xb;
  endfunction

  function automatic logic [127:0] ref_any(logic [63:0] a, logic [63:0] b,
                                           logic [1:0] m, logic s);
    case (m)
      2'b00:   return ref_full(a, b, s);
      2'b01:   return {ref_lane(a[63:32], b[63:32], s), ref_lane(a[31:0], b[31:0], s)};
      2'b10:   return ref_mant(a, b);
      default: return '0;
    endcase
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at the falling edge, sample 1 ns later, well before the rising edge
  task automatic apply(logic [63:0] a, logic [63:0] b, logic [1:0] m, logic s);
    @(negedge clk);
    op_a = a; op_b = b; mode_sel = m; is_signed = s;
    #1;
  endtask

  task automatic run(string req, logic [63:0] a, logic [63:0] b, logic [1:0] m, logic s);
    apply(a, b, m, s);
    check(req, product, ref_any(a, b, m, s));
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic t_reset();
    apply(64'd0, 64'd0, 2'b00, 1'b0);
    check("R1 idle zero", product, 128'd0);
  endtask

  task automatic t_full_unsigned();  // R1
    run("R1", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'b00, 1'b0);
    run("R1", 64'h8000_0000_0000_0000, 64'd2, 2'b00, 1'b0);
    run("R1", 64'h1234_5678_9ABC_DEF0, 64'd1, 2'b00, 1'b0);
    for (int i = 0; i < 40; i++) run("R1", rnd64(), rnd64(), 2'b00, 1'b0);
  endtask

  task automatic t_full_signed();  // R2
    run("R2", 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 2'b00, 1'b1);
    run("R2", 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 2'b00, 1'b1);
    run("R2", 64'hFFFF_FFFF_FFFF_FFFD, 64'd7, 2'b00, 1'b1);
    run("R2", 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001, 2'b00, 1'b1);
    for (int i = 0; i < 40; i++) run("R2", rnd64(), rnd64(), 2'b00, 1'b1);
  endtask

  task automatic t_simd_unsigned();  // R3
    run("R3", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'b01, 1'b0);
    run("R3", 64'h0000_0003_0000_0005, 64'h0000_0007_0000_000B, 2'b01, 1'b0);
    for (int i = 0; i < 40; i++) run("R3", rnd64(), rnd64(), 2'b01, 1'b0);
  endtask

  task automatic t_simd_signed();  // R5
    run("R5", 64'h8000_0000_8000_0000, 64'h8000_0000_FFFF_FFFF, 2'b01, 1'b1);
    run("R5", 64'hFFFF_FFFF_0000_0005, 64'h0000_0003_FFFF_FFF9, 2'b01, 1'b1);
    for (int i = 0; i < 40; i++) run("R5", rnd64(), rnd64(), 2'b01, 1'b1);
  endtask

  task automatic t_simd_isolation();  // R4
    logic [63:0] lane0_ref;
    apply(64'h0000_0000_DEAD_BEEF, 64'h0000_0000_1234_5678, 2'b01, 1'b1);
    lane0_ref = product[63:0];
    check("R4 lane1 zero", product[127:64], 128'd0);
    apply(64'hFFFF_FFFF_DEAD_BEEF, 64'hFFFF_FFFF_1234_5678, 2'b01, 1'b1);
    check("R4 lane0 kept", {64'd0, product[63:0]}, {64'd0, lane0_ref});
    apply(64'h1234_5678_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 2'b01, 1'b0);
    check("R4 lane0 zero", {64'd0, product[63:0]}, 128'd0);
    check("R4 lane1", {64'd0, product[127:64]},
          {64'd0, ref_lane(32'h1234_5678, 32'hFFFF_FFFF, 1'b0)});
  endtask

  task automatic t_mant();  // R6, R7
    logic [127:0] first;
    run("R6", 64'h001F_FFFF_FFFF_FFFF, 64'h001F_FFFF_FFFF_FFFF, 2'b10, 1'b0);
    apply(64'h0010_0000_0000_0001, 64'h0018_0000_0000_0003, 2'b10, 1'b0);
    first = product;
    apply(64'hFFF0_0000_0000_0001, 64'hABD8_0000_0000_0003, 2'b10, 1'b0);
    check("R6 high bits ignored", product, first);
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'b10, 1'b1);
    check("R7 signed ignored", product, ref_mant(64'h001F_FFFF_FFFF_FFFF, 64'h001F_FFFF_FFFF_FFFF));
    check("R7 top zero", {106'd0, product[127:106]}, 128'd0);
    for (int i = 0; i < 30; i++) run("R6", rnd64(), rnd64(), 2'b10, 1'(i % 2));
  endtask

  task automatic t_rsvd();  // R8
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, 2'b11, 1'b0);
    check("R8", product, 128'd0);
    apply(rnd64(), rnd64(), 2'b11, 1'b1);
    check("R8", product, 128'd0);
  endtask

  task automatic t_comb();  // R9: two input changes inside one clock period
    @(negedge clk);
    op_a = 64'd6; op_b = 64'd7; mode_sel = 2'b00; is_signed = 1'b0;
    #0.5;
    check("R9 first", product, 128'd42);
    op_b = 64'd9;
    #0.5;
    check("R9 follow", product, 128'd54);
    mode_sel = 2'b11;
    #0.5;
    check("R9 mode", product, 128'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset();
    t_full_unsigned();
    t_full_signed();
    t_simd_unsigned();
    t_simd_signed();
    t_simd_isolation();
    t_mant();
    t_rsvd();
    t_comb();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule